// File: doc/BRIEF.md
# Bridge Configuration Space Register File

This block holds the configuration registers of a PCI-to-PCI bridge acting as a root port. It covers the 64-byte type-1 header and can also carry a PCI Express capability structure placed directly after it. Every dword has its own attribute masks that mark each bit as read-only, read-write, write-one-to-clear, or reserved. A compile-time parameter selects PCI Express mode, and that choice changes several of the masks. A second parameter removes the prefetchable window.

A host issues one access per cycle. Each access carries a byte address, a size of 1, 2 or 4 bytes, write data and a write flag. The response comes exactly one cycle later, with read data and an error flag. Hardware logic can set status bits by giving a dword index and a bit pattern. Only bits that software clears by writing ones react to that pattern.

Top module: `bcs_regfile`

## Requirements
- R1: After reset the registers hold the following values, and every other bit reads zero.
  - The dword at 0x08 reads 0x0604_0000.
  - The dword at 0x0C reads 0x0001_0010.
  - The status half of the dword at 0x04 reads 0x0010.
  - The byte at 0x34 reads 0x40 in PCI Express mode and 0x00 otherwise.
  - In PCI Express mode the dword at 0x40 reads 0x0040_0010.
- R2: Every cycle with `req_valid` high is answered by `rsp_valid` high in the next cycle. A cycle without a request is followed by `rsp_valid` low.
- R3: Reads shift and zero-extend the selected bits.
  - The dword read is the one at the address with bits 1:0 cleared.
  - A 1-byte read returns that dword shifted right by 8 times `addr[1:0]`, keeping bits 7:0.
  - A 2-byte read does the same shift and keeps bits 15:0.
  - A 4-byte read ignores `addr[1:0]`.
- R4: A read always returns zero in bits that are neither read-only, read-write nor write-one-to-clear in that dword. This applies even after writing all ones.
- R5: A write forms a byte-lane mask and updates only the read-write bits inside it.
  - For 1 and 2 bytes the mask is 0xFF or 0xFFFF shifted left by 8 times `addr[1:0]`. Write data is shifted the same way.
  - For 4 bytes the mask is all ones.
  - Read-write bits inside the mask take the data. All other bits keep their value.
- R6: A write-one-to-clear bit clears only when it lies inside the lane mask and its data bit is 1.
- R7: An in-range access whose size is not 1, 2 or 4 returns `rsp_err` high and read data 0. It changes no register.
- R8: An access at or beyond the end of the space returns 0 with `rsp_err` low, and a write there changes nothing. The end is byte 0x7C in PCI Express mode and 0x40 otherwise.
- R9: The base/limit windows have fixed writable fields.
  - In the dword at 0x1C, bits 15:12 and 7:4 are writable.
  - In the dwords at 0x20 and 0x24, bits 31:20 and 15:4 are writable. Their low nibbles read as constants.
  - With `NO_PREF_WIN` set, the dword at 0x24 accepts no writes.
- R10: The bridge-control half of the dword at 0x3C depends on the mode.
  - Conventional mode: bits 0,1,2,3,5,6,8,9,11 are read-write and bit 10 is write-one-to-clear.
  - PCI Express mode: bits 0,1,2,3,6 are read-write, and bits 5,8,9,10,11 are reserved.
- R11: Capability structure fields, in PCI Express mode:
  - link status bits 15:14 at 0x52 are write-one-to-clear.
  - slot control bits 14:0 at 0x58 are read-write.
  - slot status bits 8 and 4:0 at 0x5A are write-one-to-clear.
  - root control bits 4:0 at 0x5C are read-write.
  - root status bit 16 at 0x60 is write-one-to-clear.
  - device control bits 14:0 at 0x48 are read-write.
  - the dword at 0x64 reads zero.
- R12: An event with `evt_valid` high sets those bits of `evt_bits` that are write-one-to-clear in dword `evt_idx`, in the next cycle. Other bits are unaffected. If a host write clears a bit in the same cycle that an event sets it, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, right-aligned for sub-dword sizes |
| evt_valid | input | 1 | Hardware status event |
| evt_idx | input | 5 | Dword index targeted by the event |
| evt_bits | input | 32 | Bits the event sets |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data, zero-extended |
| rsp_err | output | 1 | Illegal access size |

## Verification
The assertions assume at most one request per cycle and the host never holds data across cycles. The write-stability properties also assume no hardware event arrives in the same cycle as the write being checked. The bench issues every access for exactly one cycle. It drives events in cycles of their own, except in the one scenario that tests the collision rule, and that scenario is not covered by the stability properties. Event indexes stay within the dwords that exist in the configured mode.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

  localparam int WORD_W = 32;
  localparam int IDX_W  = 5;
  localparam int MAX_DW = 1 << IDX_W;

  typedef struct packed {
    logic [WORD_W-1:0] ro;
    logic [WORD_W-1:0] rw;
    logic [WORD_W-1:0] w1c;
  } dw_attr_t;

  // Per-dword bit behaviour; cap dwords exist only in express mode.
  function automatic dw_attr_t dword_attr(input logic [IDX_W-1:0] idx,
                                          input logic pcie, input logic nopref);
    dw_attr_t a;
    a = '0;
    case (idx)
      5'd0, 5'd2, 5'd4, 5'd5, 5'd14: a.ro = '1;
      5'd1: begin
        a.rw  = 32'h0000_0147;
        a.ro  = pcie ? 32'h0010_0000 : 32'h06B0_02B8;
        a.w1c = 32'hF900_0000;
      end
      5'd3: a.ro = pcie ? 32'hFFFF_00FF : '1;
      5'd6: begin
        a.rw = 32'h00FF_FFFF;
        a.ro = pcie ? 32'h0 : 32'hFF00_0000;
      end
      5'd7: begin
        a.rw  = 32'h0000_F0F0;
        a.ro  = pcie ? 32'h0000_0F0F : 32'h06A0_0F0F;
        a.w1c = 32'hF900_0000;
      end
      5'd8: begin
        a.rw = 32'hFFF0_FFF0;
        a.ro = 32'h000F_000F;
      end
      5'd9: begin
        a.rw = nopref ? 32'h0 : 32'hFFF0_FFF0;
        a.ro = nopref ? '1 : 32'h000F_000F;
      end
      5'd10, 5'd11, 5'd12: a.rw = '1;
      5'd13: a.ro = 32'h0000_00FF;
      5'd15: begin
        a.rw  = pcie ? 32'h004F_00FF : 32'h0B6F_00FF;
        a.ro  = pcie ? 32'h0000_FF00 : 32'h0080_FF00;
        a.w1c = pcie ? 32'h0 : 32'h0400_0000;
      end
      5'd16: a.ro = 32'h7FFF_FFFF;
      5'd17: a.ro = 32'h0000_803F;
      5'd18: begin
        a.rw  = 32'h0000_7FFF;
        a.w1c = 32'h000F_0000;
        a.ro  = 32'h0030_0000;
      end
      5'd19: a.ro = 32'hFF7B_FFFF;
      5'd20: begin
        a.rw  = 32'h0000_CEFB;
        a.ro  = 32'h3FFF_0000;
        a.w1c = 32'hC000_0000;
      end
      5'd21: a.ro = '1;
      5'd22: begin
        a.rw  = 32'h0000_7FFF;
        a.w1c = 32'h011F_0000;
        a.ro  = 32'h00E0_0000;
      end
      5'd23: begin
        a.rw = 32'h0000_001F;
        a.ro = 32'h0001_0000;
      end
      5'd24: begin
        a.ro  = 32'h0002_FFFF;
        a.w1c = 32'h0001_0000;
      end
      default: a = '0;
    endcase
    if (!pcie && idx >= 5'd16) a = '0;
    return a;
  endfunction

  function automatic logic [WORD_W-1:0] dword_init(input logic [IDX_W-1:0] idx,
                                                   input logic pcie);
    case (idx)
      5'd1:    return 32'h0010_0000;
      5'd2:    return 32'h0604_0000;
      5'd3:    return 32'h0001_0010;
      5'd13:   return pcie ? 32'h0000_0040 : 32'h0;
      5'd16:   return pcie ? 32'h0040_0010 : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic size_legal(input logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

  function automatic logic [4:0] lane_shift(input logic [2:0] sz, input logic [1:0] off);
    return (sz == 3'd4) ? 5'd0 : {off, 3'b000};
  endfunction

  function automatic logic [WORD_W-1:0] lane_mask(input logic [2:0] sz, input logic [1:0] off);
    case (sz)
      3'd1:    return 32'h0000_00FF << lane_shift(sz, off);
      3'd2:    return 32'h0000_FFFF << lane_shift(sz, off);
      3'd4:    return '1;
      default: return '0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] pick_lanes(input logic [WORD_W-1:0] w,
                                                   input logic [2:0] sz, input logic [1:0] off);
    case (sz)
      3'd1:    return (w >> lane_shift(sz, off)) & 32'h0000_00FF;
      3'd2:    return (w >> lane_shift(sz, off)) & 32'h0000_FFFF;
      default: return w;
    endcase
  endfunction

  // Write merge, then hardware set; set is applied last so it wins.
  function automatic logic [WORD_W-1:0] next_word(input logic [WORD_W-1:0] old,
                                                  input dw_attr_t a,
                                                  input logic wr, input logic [WORD_W-1:0] data,
                                                  input logic [WORD_W-1:0] lane,
                                                  input logic set, input logic [WORD_W-1:0] bits);
    logic [WORD_W-1:0] n;
    n = old;
    if (wr) begin
      n = (n & ~(a.rw & lane)) | (data & a.rw & lane);
      n = n & ~(data & a.w1c & lane);
    end
    if (set) n = n | (bits & a.w1c);
    return n & (a.rw | a.w1c);
  endfunction

endpackage

// File: rtl/cfg_access_decode.sv
module cfg_access_decode
  import cfg_space_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int END_BYTE = 124
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  output logic [IDX_W-1:0]  idx,
  output logic              in_range,
  output logic              size_ok,
  output logic [4:0]        shamt,
  output logic [WORD_W-1:0] lane
);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(END_BYTE);

  assign idx      = addr[IDX_W+1:2];
  assign in_range = addr < LIMIT;
  assign size_ok  = size_legal(size);
  assign shamt    = lane_shift(size, addr[1:0]);
  assign lane     = lane_mask(size, addr[1:0]);
endmodule

// File: rtl/cfg_dword_cell.sv
module cfg_dword_cell
  import cfg_space_pkg::*;
#(
  parameter int IDX         = 0,
  parameter bit PCIE_CAP    = 1'b1,
  parameter bit NO_PREF_WIN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_lane,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              set_en,
  input  logic [WORD_W-1:0] set_bits,
  output logic [WORD_W-1:0] word_o
);
  localparam dw_attr_t          ATTR = dword_attr(IDX_W'(IDX), PCIE_CAP, NO_PREF_WIN);
  localparam logic [WORD_W-1:0] INIT = dword_init(IDX_W'(IDX), PCIE_CAP);

  logic [WORD_W-1:0] held_q, held_d;

  always_comb held_d = next_word(held_q, ATTR, wr_en, wr_data, wr_lane, set_en, set_bits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= INIT & (ATTR.rw | ATTR.w1c);
    else        held_q <= held_d;
  end

  assign word_o = held_q | (INIT & ATTR.ro);
endmodule

// File: rtl/bcs_regfile.sv
module bcs_regfile
  import cfg_space_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter bit PCIE_CAP    = 1'b1,
  parameter bit NO_PREF_WIN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic [31:0]       req_wdata,
  input  logic              evt_valid,
  input  logic [4:0]        evt_idx,
  input  logic [31:0]       evt_bits,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err
);
  localparam int NUM_DW   = PCIE_CAP ? 31 : 16;
  localparam int END_BYTE = PCIE_CAP ? 124 : 64;

  logic [IDX_W-1:0]  acc_idx;
  logic              acc_in_range, acc_size_ok, acc_bad_size;
  logic [4:0]        acc_shamt;
  logic [WORD_W-1:0] acc_lane, wr_shifted, rd_word;
  logic              wr_fire, rd_fire;
  logic [WORD_W-1:0] words [MAX_DW];
  logic [MAX_DW*WORD_W-1:0] state_flat;

  cfg_access_decode #(.ADDR_W(ADDR_W), .END_BYTE(END_BYTE)) u_dec (
    .addr(req_addr), .size(req_size), .idx(acc_idx), .in_range(acc_in_range),
    .size_ok(acc_size_ok), .shamt(acc_shamt), .lane(acc_lane)
  );

  assign acc_bad_size = !acc_size_ok;
  assign wr_fire      = req_valid && req_write && acc_in_range && acc_size_ok;
  assign rd_fire      = req_valid && !req_write && acc_in_range && acc_size_ok;
  assign wr_shifted   = req_wdata << acc_shamt;

  for (genvar g = 0; g < MAX_DW; g++) begin : g_dw
    if (g < NUM_DW) begin : g_cell
      cfg_dword_cell #(.IDX(g), .PCIE_CAP(PCIE_CAP), .NO_PREF_WIN(NO_PREF_WIN)) u_cell (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_fire && (acc_idx == IDX_W'(g))), .wr_lane(acc_lane), .wr_data(wr_shifted),
        .set_en(evt_valid && (evt_idx == IDX_W'(g))), .set_bits(evt_bits),
        .word_o(words[g])
      );
    end else begin : g_none
      assign words[g] = '0;
    end
    assign state_flat[g*WORD_W +: WORD_W] = words[g];
  end

  assign rd_word = words[acc_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && acc_in_range && acc_bad_size;
      rsp_rdata <= rd_fire ? pick_lanes(rd_word, req_size, req_addr[1:0]) : '0;
    end
  end
endmodule

// File: rtl/bcs_regfile_chk.sv
module bcs_regfile_chk
  import cfg_space_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter bit PCIE_CAP    = 1'b1,
  parameter bit NO_PREF_WIN = 1'b0
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_write,
  input logic [ADDR_W-1:0]        req_addr,
  input logic [2:0]               req_size,
  input logic                     evt_valid,
  input logic [4:0]               evt_idx,
  input logic [31:0]              evt_bits,
  input logic                     rsp_valid,
  input logic [31:0]              rsp_rdata,
  input logic                     rsp_err,
  input logic                     acc_in_range,
  input logic                     acc_bad_size,
  input logic [MAX_DW*WORD_W-1:0] state_flat
);
  logic              evt_chk_q;
  logic [IDX_W-1:0]  evt_idx_q;
  logic [WORD_W-1:0] evt_need_q, evt_word;
  dw_attr_t          evt_attr;

  assign evt_attr = dword_attr(evt_idx, PCIE_CAP, NO_PREF_WIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_chk_q  <= 1'b0;
      evt_idx_q  <= '0;
      evt_need_q <= '0;
    end else begin
      evt_chk_q  <= evt_valid;
      evt_idx_q  <= evt_idx;
      evt_need_q <= evt_bits & evt_attr.w1c;
    end
  end

  assign evt_word = state_flat[{evt_idx_q, 5'b00000} +: WORD_W];

  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_idle_no_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_bad_size_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc_in_range && acc_bad_size) |=> (rsp_err && rsp_rdata == 32'h0));
  p_bad_size_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && acc_in_range && acc_bad_size && !evt_valid) |=> $stable(state_flat));
  p_oob_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !acc_in_range) |=> (!rsp_err && rsp_rdata == 32'h0));
  p_oob_write_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !acc_in_range && !evt_valid) |=> $stable(state_flat));
  p_byte_read_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size == 3'd1) |=> (rsp_rdata[31:8] == 24'h0));
  p_half_read_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size == 3'd2) |=> (rsp_rdata[31:16] == 16'h0));
  p_evt_sets_r12: assert property (@(posedge clk) disable iff (!rst_n)
    evt_chk_q |-> ((evt_word & evt_need_q) == evt_need_q));
endmodule

bind bcs_regfile bcs_regfile_chk #(
  .ADDR_W(ADDR_W), .PCIE_CAP(PCIE_CAP), .NO_PREF_WIN(NO_PREF_WIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_size(req_size), .evt_valid(evt_valid), .evt_idx(evt_idx),
  .evt_bits(evt_bits), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
  .acc_in_range(acc_in_range), .acc_bad_size(acc_bad_size), .state_flat(state_flat)
);

// File: tb/tb_bcs_regfile.sv
`timescale 1ns/1ps
module tb_bcs_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [2:0]  req_size = 3'd4;
  logic [31:0] req_wdata = '0;
  logic        evt_valid = 1'b0;
  logic [4:0]  evt_idx = '0;
  logic [31:0] evt_bits = '0;
  logic        x_valid, x_err, c_valid, c_err;
  logic [31:0] x_rdata, c_rdata;
  logic [31:0] gx, gc;
  logic        ex, ec, vx;
  int n_vec = 0, n_bad = 0;

  always #4 clk = ~clk;

  // express mode, prefetchable window present
  bcs_regfile dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .evt_valid(evt_valid), .evt_idx(evt_idx), .evt_bits(evt_bits),
    .rsp_valid(x_valid), .rsp_rdata(x_rdata), .rsp_err(x_err));

  // conventional mode, no prefetchable window
  bcs_regfile #(.PCIE_CAP(1'b0), .NO_PREF_WIN(1'b1)) dut_c (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .evt_valid(evt_valid), .evt_idx(evt_idx), .evt_bits(evt_bits),
    .rsp_valid(c_valid), .rsp_rdata(c_rdata), .rsp_err(c_err));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  // one access, optionally with a simultaneous event; caller is at a negedge
  task automatic acc_ev(input logic w, input logic [11:0] a, input logic [2:0] s,
                        input logic [31:0] d, input logic ev, input logic [4:0] ei,
                        input logic [31:0] eb);
    req_valid = 1'b1; req_write = w; req_addr = a; req_size = s; req_wdata = d;
    evt_valid = ev; evt_idx = ei; evt_bits = eb;
    @(negedge clk);
    gx = x_rdata; gc = c_rdata; ex = x_err; ec = c_err; vx = x_valid;
    req_valid = 1'b0; evt_valid = 1'b0;
  endtask

  task automatic acc(input logic w, input logic [11:0] a, input logic [2:0] s, input logic [31:0] d);
    acc_ev(w, a, s, d, 1'b0, 5'd0, 32'h0);
  endtask

  task automatic event_only(input logic [4:0] ei, input logic [31:0] eb);
    evt_valid = 1'b1; evt_idx = ei; evt_bits = eb;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic t_reset;
    acc(0, 12'h008, 3'd4, 0); check("R1 class x", gx, 32'h0604_0000); check("R1 class c", gc, 32'h0604_0000);
    acc(0, 12'h00C, 3'd4, 0); check("R1 hdr x", gx, 32'h0001_0010); check("R1 hdr c", gc, 32'h0001_0010);
    acc(0, 12'h006, 3'd2, 0); check("R1 status", gx, 32'h0000_0010);
    acc(0, 12'h034, 3'd1, 0); check("R1 capptr x", gx, 32'h40); check("R1 capptr c", gc, 32'h00);
    acc(0, 12'h040, 3'd4, 0); check("R1 capid x", gx, 32'h0040_0010); check("R8 oob c", gc, 32'h0);
  endtask

  task automatic t_latency;
    acc(0, 12'h000, 3'd4, 0); check("R2 rsp_valid", {31'h0, vx}, 32'h1);
    @(negedge clk); check("R2 idle", {31'h0, x_valid}, 32'h0);
  endtask

  task automatic t_merge;
    acc(1, 12'h018, 3'd4, 32'hFFFF_FFFF);
    acc(0, 12'h018, 3'd4, 0); check("R5 full x", gx, 32'h00FF_FFFF); check("R5 full c", gc, 32'h00FF_FFFF);
    acc(1, 12'h019, 3'd1, 32'h0000_0000);
    acc(0, 12'h018, 3'd4, 0); check("R5 byte lane", gx, 32'h00FF_00FF);
    acc(1, 12'h01A, 3'd2, 32'h0000_1234);
    acc(0, 12'h018, 3'd4, 0); check("R5 half lane", gx, 32'h0034_00FF);
  endtask

  task automatic t_reads;
    acc(0, 12'h019, 3'd1, 0); check("R3 byte", gx, 32'h00);
    acc(0, 12'h01A, 3'd2, 0); check("R3 half", gx, 32'h0034);
    acc(0, 12'h01B, 3'd2, 0); check("R3 half top", gx, 32'h0000);
    acc(0, 12'h01A, 3'd4, 0); check("R3 full unaligned", gx, 32'h0034_00FF);
  endtask

  task automatic t_windows;
    acc(1, 12'h01C, 3'd2, 32'hFFFF);
    acc(0, 12'h01C, 3'd4, 0); check("R9 io x", gx, 32'h0000_F0F0); check("R9 io c", gc, 32'h0000_F0F0);
    acc(1, 12'h020, 3'd4, 32'hFFFF_FFFF);
    acc(0, 12'h020, 3'd4, 0); check("R9 mem", gx, 32'hFFF0_FFF0);
    acc(1, 12'h024, 3'd4, 32'hFFFF_FFFF);
    acc(0, 12'h024, 3'd4, 0); check("R9 pref x", gx, 32'hFFF0_FFF0); check("R9 nopref c", gc, 32'h0);
  endtask

  task automatic t_w1c;
    event_only(5'd1, 32'hFFFF_FFFF);
    acc(0, 12'h004, 3'd4, 0); check("R12 evt set x", gx, 32'hF910_0000); check("R12 evt set c", gc, 32'hF910_0000);
    acc(1, 12'h006, 3'd2, 32'h0800);
    acc(0, 12'h004, 3'd4, 0); check("R6 clear one", gx, 32'hF110_0000);
    acc(1, 12'h004, 3'd1, 32'hFF);
    acc(0, 12'h004, 3'd4, 0); check("R6 outside lane kept", gx, 32'hF110_0047);
  endtask

  task automatic t_collide;
    acc_ev(1, 12'h007, 3'd1, 32'h80, 1'b1, 5'd1, 32'h8000_0000);
    acc(0, 12'h004, 3'd4, 0); check("R12 set wins", gx, 32'hF110_0047);
    acc(1, 12'h007, 3'd1, 32'h80);
    acc(0, 12'h004, 3'd4, 0); check("R6 clear bit31", gx, 32'h7110_0047);
    event_only(5'd6, 32'hFFFF_FFFF);
    acc(0, 12'h018, 3'd4, 0); check("R12 non-w1c ignored", gx, 32'h0034_00FF);
  endtask

  task automatic t_errors;
    acc(1, 12'h018, 3'd3, 32'h0);
    check("R7 err write", {31'h0, ex}, 32'h1);
    acc(0, 12'h018, 3'd4, 0); check("R7 no change", gx, 32'h0034_00FF);
    acc(0, 12'h018, 3'd0, 0); check("R7 err read", {31'h0, ex}, 32'h1); check("R7 zero data", gx, 32'h0);
    acc(0, 12'h07C, 3'd4, 0); check("R8 end x", gx, 32'h0); check("R8 no err", {31'h0, ex}, 32'h0);
    acc(1, 12'h098, 3'd4, 32'h0);
    acc(0, 12'h018, 3'd4, 0); check("R8 alias ignored x", gx, 32'h0034_00FF); check("R8 alias ignored c", gc, 32'h0034_00FF);
    acc(0, 12'h090, 3'd3, 0); check("R8 oob bad size no err", {31'h0, ex}, 32'h0);
  endtask

  task automatic t_bridge_ctl;
    acc(1, 12'h03C, 3'd4, 32'hFFFF_FFFF);
    acc(0, 12'h03C, 3'd4, 0); check("R10 ctl x", gx, 32'h004F_00FF); check("R10 ctl c", gc, 32'h0B6F_00FF);
    event_only(5'd15, 32'h0400_0000);
    acc(0, 12'h03C, 3'd4, 0); check("R10 rsvd x", gx, 32'h004F_00FF); check("R10 w1c c", gc, 32'h0F6F_00FF);
    acc(1, 12'h03E, 3'd2, 32'h0400);
    acc(0, 12'h03C, 3'd4, 0); check("R10 half x", gx, 32'h0000_00FF); check("R10 half c", gc, 32'h0000_00FF);
  endtask

  task automatic t_caps;
    acc(1, 12'h048, 3'd4, 32'hFFFF_FFFF);
    acc(0, 12'h048, 3'd4, 0); check("R4 devctl", gx, 32'h0000_7FFF);
    acc(1, 12'h064, 3'd4, 32'hFFFF_FFFF);
    acc(0, 12'h064, 3'd4, 0); check("R4 rsvd dword", gx, 32'h0);
    event_only(5'd20, 32'hFFFF_FFFF);
    acc(0, 12'h050, 3'd4, 0); check("R11 link set", gx, 32'hC000_0000);
    acc(1, 12'h052, 3'd2, 32'h4000);
    acc(0, 12'h050, 3'd4, 0); check("R11 link clear", gx, 32'h8000_0000);
    acc(1, 12'h058, 3'd4, 32'hFFFF_FFFF);
    event_only(5'd22, 32'hFFFF_FFFF);
    acc(0, 12'h058, 3'd4, 0); check("R11 slot", gx, 32'h011F_7FFF);
    acc(1, 12'h05C, 3'd4, 32'hFFFF_FFFF);
    acc(0, 12'h05C, 3'd4, 0); check("R11 rootctl", gx, 32'h0000_001F);
    event_only(5'd24, 32'hFFFF_FFFF);
    acc(0, 12'h060, 3'd4, 0); check("R11 rootsta set", gx, 32'h0001_0000);
    acc(1, 12'h060, 3'd4, 32'h0001_FFFF);
    acc(0, 12'h060, 3'd4, 0); check("R11 rootsta clear", gx, 32'h0);
  endtask

  initial begin
    #(8 * 150000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got %0d expected 0 (timeout)", 1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 rsp after reset", {29'h0, x_valid, x_err, c_err}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_merge();
    t_reads();
    t_windows();
    t_w1c();
    t_collide();
    t_errors();
    t_bridge_ctl();
    t_caps();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule